// File: doc/BRIEF.md
# Shift, Rotate and Compare Unit

This is the 8-bit data-manipulation unit of a small controller. One operation is presented on its input stream each cycle: an operation code, the register operand, an immediate byte and a bit count. The unit shifts or rotates the operand by the count, or runs a flag-only test of the operand against the immediate. It returns the result byte, a write strobe that tells the register file whether to store that result, and the new condition flags.

The unit keeps the condition flags itself, because several operations must leave some or all of the flags as they were. Both edges of the block are valid/ready streams. An operation is taken when `in_valid` and `in_ready` are both high on a rising clock edge. A result is handed over when `out_valid` and `out_ready` are both high on a rising edge. With `REG_OUT = 1`, which is the default, the results pass through one register stage. In that case `in_ready` is high whenever the stage is empty or is being drained in the same cycle. A stalled result stays unchanged until it is taken. With `REG_OUT = 0` the path is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Operation codes on `in_op`: 0 shift left, 1 shift right, 2 rotate left, 3 compare, 4 bit test, 5 to 7 undefined. The flags are held in a bus with bit 0 = Z (zero), bit 1 = N (negative), bit 2 = C (carry/borrow) and bit 3 = V (overflow).

Top module: `ssc_unit`

## Requirements
- R1: Shift left (op 0) with count k from 1 to 7 returns the operand moved left by k places, with zeros filling the low bits. C becomes original operand bit 8-k, the last bit pushed out of the top. Z is set when the result is 0x00, N copies result bit 7, V is unchanged, and `out_wr` is 1.
- R2: Shift right (op 1) with count k from 1 to 7 returns the operand moved right by k places, with zeros filling the high bits. C becomes original operand bit k-1. Z and N are taken from the result, V is unchanged, and `out_wr` is 1.
- R3: Rotate left (op 2) with count k from 1 to 7 returns the operand turned left by k places, each bit leaving bit 7 re-entering at bit 0. C equals the new bit 0. Z and N are taken from the result, V is unchanged, and `out_wr` is 1.
- R4: A shift or rotate with count 0 returns the operand unchanged with `out_wr` = 1, and leaves all four flags as they were.
- R5: Compare (op 3) returns the operand as result with `out_wr` = 0. Z and N are taken from (register − immediate) mod 256. C is set when register < immediate (unsigned). V is set when the signed difference falls outside −128..127.
- R6: Bit test (op 4) returns the operand as result with `out_wr` = 0. Z and N are taken from (register AND immediate). C and V are unchanged.
- R7: Op codes 5, 6 and 7 return the operand with `out_wr` = 0 and leave all flags unchanged.
- R8: With `REG_OUT` = 1, `in_ready` is high whenever no result is held or `out_ready` is high. A held result with `out_ready` low keeps `out_valid`, `out_result`, `out_wr` and `out_flags` unchanged. Results leave in the order the operations were taken, none lost or repeated.
- R9: During reset `out_valid` is 0, `out_flags` is 0000 and `in_ready` is 1. The flag state starts at 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can take the operation |
| in_op | input | 3 | Operation code |
| in_reg | input | DATA_W | Register operand |
| in_imm | input | DATA_W | Immediate operand for compare and bit test |
| in_cnt | input | CNT_W | Shift or rotate count |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | DATA_W | Result byte |
| out_wr | output | 1 | Store the result into the register |
| out_flags | output | 4 | New flags {V, C, N, Z} |

## Verification
Two things often fall in the same cycle: the output stage stalling on a low `out_ready`, and the flag state being read by the next operation. Compare, bit test, zero-count shifts and undefined codes are sent back to back while a repeating pattern pulls `out_ready` low every third cycle. The next operation then waits at the input while it depends on flags that the stalled predecessor already updated. A scoreboard built from a bit-by-bit model in the bench holds the expected result, strobe and flags for each accepted operation, and compares them in order as results are taken. Every stalled cycle is also checked for an output that stays unchanged.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_ROT = 3'd2,
    OP_CMP = 3'd3,
    OP_BIT = 3'd4
  } ssc_op_e;

  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } ssc_flags_t;
endpackage

// File: rtl/ssc_shifter.sv
module ssc_shifter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] res,
  output logic              cout,
  output logic              moved
);
  import ssc_pkg::*;

  logic [DATA_W:0]     ext;
  logic [2*DATA_W-1:0] dbl;

  always_comb begin
    res  = data;
    cout = 1'b0;
    ext  = '0;
    dbl  = '0;
    case (op)
      OP_SHL: begin
        ext  = {1'b0, data} << cnt;
        res  = ext[DATA_W-1:0];
        cout = ext[DATA_W];
      end
      OP_SHR: begin
        ext  = {data, 1'b0} >> cnt;
        res  = ext[DATA_W:1];
        cout = ext[0];
      end
      OP_ROT: begin
        dbl  = {data, data} << cnt;
        res  = dbl[2*DATA_W-1:DATA_W];
        cout = dbl[DATA_W];
      end
      default: ;
    endcase
  end

  assign moved = (op == OP_SHL || op == OP_SHR || op == OP_ROT) && (cnt != '0);
endmodule

// File: rtl/ssc_tester.sv
module ssc_tester #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] val,
  output logic              borrow,
  output logic              ovf
);
  import ssc_pkg::*;

  logic [DATA_W:0] diff;

  always_comb begin
    diff   = {1'b0, a} - {1'b0, b};
    val    = a & b;
    borrow = 1'b0;
    ovf    = 1'b0;
    if (op == OP_CMP) begin
      val    = diff[DATA_W-1:0];
      borrow = diff[DATA_W];
      ovf    = (a[DATA_W-1] ^ b[DATA_W-1]) & (diff[DATA_W-1] ^ a[DATA_W-1]);
    end
  end
endmodule

// File: rtl/ssc_flag_merge.sv
module ssc_flag_merge #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        op,
  input  logic              moved,
  input  logic [DATA_W-1:0] shift_res,
  input  logic              shift_c,
  input  logic [DATA_W-1:0] test_val,
  input  logic              test_c,
  input  logic              test_v,
  input  logic [3:0]        old_flags,
  output logic [3:0]        new_flags,
  output logic              wr
);
  import ssc_pkg::*;

  ssc_flags_t f_old, f_new;

  always_comb begin
    f_old = ssc_flags_t'(old_flags);
    f_new = f_old;
    wr    = 1'b0;
    case (op)
      OP_SHL, OP_SHR, OP_ROT: begin
        wr = 1'b1;
        if (moved) begin
          f_new.c = shift_c;
          f_new.n = shift_res[DATA_W-1];
          f_new.z = (shift_res == '0);
        end
      end
      OP_CMP: begin
        f_new.v = test_v;
        f_new.c = test_c;
        f_new.n = test_val[DATA_W-1];
        f_new.z = (test_val == '0);
      end
      OP_BIT: begin
        f_new.n = test_val[DATA_W-1];
        f_new.z = (test_val == '0);
      end
      default: ;
    endcase
    new_flags = f_new;
  end
endmodule

// File: rtl/ssc_out_stage.sv
module ssc_out_stage #(
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] d_result,
  input  logic              d_wr,
  input  logic [3:0]        d_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr,
  output logic [3:0]        out_flags
);
  generate
    if (REG_OUT) begin : g_reg
      logic              vld_q;
      logic [DATA_W-1:0] res_q;
      logic              wr_q;
      logic [3:0]        flg_q;

      assign in_ready = !vld_q || out_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
          wr_q  <= 1'b0;
          flg_q <= '0;
        end else if (in_valid && in_ready) begin
          vld_q <= 1'b1;
          res_q <= d_result;
          wr_q  <= d_wr;
          flg_q <= d_flags;
        end else if (out_ready) begin
          vld_q <= 1'b0;
        end
      end

      assign out_valid  = vld_q;
      assign out_result = res_q;
      assign out_wr     = wr_q;
      assign out_flags  = flg_q;
    end else begin : g_comb
      assign in_ready   = out_ready;
      assign out_valid  = in_valid;
      assign out_result = d_result;
      assign out_wr     = d_wr;
      assign out_flags  = d_flags;
    end
  endgenerate
endmodule

// File: rtl/ssc_unit.sv
module ssc_unit #(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = $clog2(DATA_W),
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_reg,
  input  logic [DATA_W-1:0] in_imm,
  input  logic [CNT_W-1:0]  in_cnt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr,
  output logic [3:0]        out_flags
);
  logic [DATA_W-1:0] sh_res, ts_val;
  logic              sh_c, sh_moved, ts_c, ts_v, nx_wr;
  logic [3:0]        flags_q, nx_flags;

  ssc_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .op(in_op), .data(in_reg), .cnt(in_cnt),
    .res(sh_res), .cout(sh_c), .moved(sh_moved)
  );

  ssc_tester #(.DATA_W(DATA_W)) u_test (
    .op(in_op), .a(in_reg), .b(in_imm),
    .val(ts_val), .borrow(ts_c), .ovf(ts_v)
  );

  ssc_flag_merge #(.DATA_W(DATA_W)) u_flags (
    .op(in_op), .moved(sh_moved), .shift_res(sh_res), .shift_c(sh_c),
    .test_val(ts_val), .test_c(ts_c), .test_v(ts_v),
    .old_flags(flags_q), .new_flags(nx_flags), .wr(nx_wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else if (in_valid && in_ready) flags_q <= nx_flags;
  end

  ssc_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .d_result(sh_res), .d_wr(nx_wr), .d_flags(nx_flags),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_wr(out_wr), .out_flags(out_flags)
  );
endmodule

// File: rtl/ssc_unit_chk.sv
module ssc_unit_chk #(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic [DATA_W-1:0] in_reg,
  input logic [CNT_W-1:0]  in_cnt,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_wr,
  input logic [3:0]        out_flags,
  input logic [3:0]        flags_q
);
  logic acc, is_test;
  assign acc     = in_valid && in_ready;
  assign is_test = (in_op == 3'd3) || (in_op == 3'd4);

  p_test_nowr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && acc && is_test) |=> !out_wr);

  p_test_nowr_comb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!REG_OUT && acc && is_test) |-> !out_wr);

  p_rot_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && acc && in_op == 3'd2) |=>
      ($countones(out_result) == $countones($past(in_reg))));

  p_cnt0_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op <= 3'd2 && in_cnt == '0) |=> (flags_q == $past(flags_q)));

  p_undef_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op > 3'd4) |=> (flags_q == $past(flags_q)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_wr) && $stable(out_flags)));

  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && !out_valid) |-> in_ready);
endmodule

bind ssc_unit ssc_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_reg(in_reg), .in_cnt(in_cnt),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_wr(out_wr), .out_flags(out_flags), .flags_q(flags_q)
);

// File: tb/test_ssc_unit.sv
module test_ssc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int CW = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n, in_valid, in_ready, out_valid, out_ready, out_wr;
  logic [2:0]    in_op;
  logic [W-1:0]  in_reg, in_imm, out_result;
  logic [CW-1:0] in_cnt;
  logic [3:0]    out_flags;

  ssc_unit #(.DATA_W(W), .CNT_W(CW), .REG_OUT(1'b1)) i_ssc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_reg(in_reg), .in_imm(in_imm), .in_cnt(in_cnt),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wr(out_wr), .out_flags(out_flags)
  );

  typedef struct {
    logic [7:0] res;
    logic       wr;
    logic [3:0] fl;
    string      req;
  } exp_t;

  exp_t       sb[$];
  int         checks = 0;
  int         fails  = 0;
  logic [3:0] mflags = 4'h0;
  bit         bp_on  = 1'b0;
  int         cyc    = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bit-by-bit reference model; flags {V,C,N,Z}
  task automatic push(logic [2:0] op, logic [7:0] r, logic [7:0] i, logic [2:0] k, string req);
    exp_t e;
    logic [7:0] rr;
    logic       c;
    int         sd;
    e.res = r;
    e.wr  = 1'b0;
    e.fl  = mflags;
    e.req = req;
    if (op <= 3'd2) begin
      rr = r;
      c  = mflags[2];
      for (int s = 0; s < int'(k); s++) begin
        case (op)
          3'd0: begin c = rr[7]; rr = {rr[6:0], 1'b0}; end
          3'd1: begin c = rr[0]; rr = {1'b0, rr[7:1]}; end
          default: begin c = rr[7]; rr = {rr[6:0], rr[7]}; end
        endcase
      end
      e.res = rr;
      e.wr  = 1'b1;
      if (k != 3'd0) e.fl = {mflags[3], c, rr[7], rr == 8'h00};
    end else if (op == 3'd3) begin
      sd = int'($signed(r)) - int'($signed(i));
      rr = r - i;
      e.fl = {(sd > 127 || sd < -128), (r < i), rr[7], (r == i)};
    end else if (op == 3'd4) begin
      rr = r & i;
      e.fl = {mflags[3], mflags[2], rr[7], rr == 8'h00};
    end
    mflags = e.fl;
    sb.push_back(e);
  endtask

  task automatic send(logic [2:0] op, logic [7:0] r, logic [7:0] i, logic [2:0] k, string req);
    push(op, r, i, k, req);
    @(negedge clk);
    in_op = op; in_reg = r; in_imm = i; in_cnt = k; in_valid = 1'b1;
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard on each result handshake; checks holds under stall
  initial begin : monitor
    logic       held;
    logic [7:0] h_res;
    logic       h_wr;
    logic [3:0] h_fl;
    exp_t       e;
    held = 1'b0; h_res = '0; h_wr = 1'b0; h_fl = '0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = !(bp_on && (cyc % 3 == 0));
      #2;
      if (rst_n) begin
        if (held) begin
          check("R8", "stalled valid", 32'(out_valid), 32'h1);
          check("R8", "stalled result", 32'(out_result), 32'(h_res));
          check("R8", "stalled wr", 32'(out_wr), 32'(h_wr));
          check("R8", "stalled flags", 32'(out_flags), 32'(h_fl));
        end
        held = out_valid && !out_ready;
        h_res = out_result; h_wr = out_wr; h_fl = out_flags;
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check("R8", "unexpected result", 32'h1, 32'h0);
          end else begin
            e = sb.pop_front();
            check(e.req, "result", 32'(out_result), 32'(e.res));
            check(e.req, "wr", 32'(out_wr), 32'(e.wr));
            check(e.req, "flags", 32'(out_flags), 32'(e.fl));
          end
        end
      end
    end
  end

  task automatic run_set();
    // R1 shift left
    send(3'd0, 8'h81, 8'h00, 3'd1, "R1");
    send(3'd0, 8'h0F, 8'h00, 3'd4, "R1");
    send(3'd0, 8'h01, 8'h00, 3'd7, "R1");
    send(3'd0, 8'h03, 8'h00, 3'd7, "R1");
    // R2 shift right
    send(3'd1, 8'h81, 8'h00, 3'd1, "R2");
    send(3'd1, 8'h80, 8'h00, 3'd7, "R2");
    send(3'd1, 8'h40, 8'h00, 3'd7, "R2");
    // R3 rotate left
    send(3'd2, 8'h81, 8'h00, 3'd1, "R3");
    send(3'd2, 8'h12, 8'h00, 3'd4, "R3");
    send(3'd2, 8'hF0, 8'h00, 3'd7, "R3");
    // R5 compare: borrow, equal, signed overflow, mixed sign
    send(3'd3, 8'h10, 8'h20, 3'd0, "R5");
    send(3'd3, 8'h20, 8'h20, 3'd5, "R5");
    send(3'd3, 8'h80, 8'h01, 3'd0, "R5");
    // R4 zero count keeps flags set by the compare just before
    send(3'd0, 8'hC3, 8'h00, 3'd0, "R4");
    send(3'd1, 8'h00, 8'h00, 3'd0, "R4");
    send(3'd2, 8'h5A, 8'h00, 3'd0, "R4");
    send(3'd3, 8'h7F, 8'hFF, 3'd0, "R5");
    // R6 bit test keeps C and V
    send(3'd4, 8'hA5, 8'h0F, 3'd0, "R6");
    send(3'd4, 8'hA5, 8'h50, 3'd0, "R6");
    send(3'd4, 8'h80, 8'hFF, 3'd3, "R6");
    // R7 undefined codes
    send(3'd5, 8'h11, 8'h22, 3'd1, "R7");
    send(3'd6, 8'h00, 8'hFF, 3'd2, "R7");
    send(3'd7, 8'hFE, 8'h01, 3'd7, "R7");
    send(3'd0, 8'h55, 8'h00, 3'd1, "R1");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired with %0d results pending", sb.size());
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_reg = '0; in_imm = '0; in_cnt = '0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    check("R9", "reset out_valid", 32'(out_valid), 32'h0);
    check("R9", "reset out_flags", 32'(out_flags), 32'h0);
    check("R9", "reset in_ready", 32'(in_ready), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    run_set();
    idle();
    bp_on = 1'b1;
    run_set();
    idle();
    for (int w = 0; w < 50 && sb.size() != 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R8", "results pending at end", 32'(sb.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule